// File: doc/BRIEF.md
# Indexed Remap Element Sequencer

This block runs a vertical-first add, xor and rotate schedule over a window of sixteen 32-bit state words. Software first fills three index tables with packed 64-bit words and writes the state words. It then pulses `start` with a repeat count. For every element of a 32-element vector, the sequencer reads one index from each table and carries out three steps in a fixed order. First it adds one indexed word into another. Next it xors the sum into a third word. Last it rotates that third word left by an amount chosen from the element number. Only then does it move to the next element.

Each index is an offset into the sixteen-word window. The index values alone decide which words every step touches, so the same engine can run any schedule that software packs into the tables. When the tables hold the column and diagonal quarter-round pattern, one vector pass equals one double round of a well-known stream cipher core. A repeat count of ten then gives the full twenty rounds.

An index that falls outside the window stops the run before any write for that element, and raises an error flag.

Top module: `vfr_seq`

## Requirements
- R1: Synchronous reset clears `busy`, `done`, `vec_end` and `err` to 0 and sets all sixteen state words to zero. A state word reads back on `st_rdata` one clock after its address is placed on `st_raddr`.
- R2: Tables 0, 1 and 2 are selected by `tbl_sel`. Each table holds 32 8-bit indices in four 64-bit words. Bits [8k+7:8k] of word w hold the index for element 8w+k. Each index is an offset from word 0 of the state window.
- R3: For element e, the add step writes S[T0[e]] + S[T1[e]] (mod 2^32) into S[T0[e]].
- R4: The xor step of element e uses the value left by its own add step. It writes S[T2[e]] xor S[T0[e]] into S[T2[e]].
- R5: The rotate step of element e rotates S[T2[e]] left by 16, 12, 8 or 7 bits when e mod 4 is 0, 1, 2 or 3 respectively.
- R6: Elements run strictly in order, and each element takes four cycles: fetch, add, xor, rotate. An accepted start with repeat count n > 0 keeps `busy` high for exactly 128*n cycles.
- R7: `vec_end` pulses for one cycle after the last element of every pass, so a run gives n pulses. `done` pulses together with the final pulse.
- R8: While `busy` is high, table loads and state writes are ignored. Both the running pass and later runs use the contents loaded beforehand.
- R9: If any of the three indices of an element is 16 or more, the block writes nothing for that element. It drops `busy` without pulsing `done` and sets `err`. `err` stays set until the next accepted start.
- R10: A start with repeat count 0 pulses `done` on the next cycle, leaves `busy` low and changes no state word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Write one packed index word (idle only) |
| tbl_sel | input | 2 | Table number 0..2 |
| tbl_word | input | 2 | Word number within the table |
| tbl_wdata | input | 64 | Packed 8-bit indices, element 8w+k in byte k |
| st_we | input | 1 | Write one state word (idle only) |
| st_waddr | input | 4 | State word address |
| st_wdata | input | 32 | State word data |
| st_raddr | input | 4 | State read address |
| st_rdata | output | 32 | Registered state read data |
| start | input | 1 | Begin a run (sampled while idle) |
| rep_count | input | 8 | Number of vector passes |
| busy | output | 1 | Run in progress |
| vec_end | output | 1 | One-cycle pulse after each pass |
| done | output | 1 | One-cycle pulse when the run completes |
| err | output | 1 | Out-of-window index seen, run halted |

## Verification
The assertions rely on three things about the inputs. `start` matters only while the block is idle. `rep_count` is sampled only on the cycle a start is accepted. Reset is held long enough to clear the sequencer state. The stimulus keeps to these rules: it raises `start` only when `busy` is low, and holds `rep_count` steady around that cycle. It pokes tables and state during a run only on purpose, to show those writes are ignored. Out-of-window indices are loaded in only one directed case, and the valid table is restored before the next run.

// File: rtl/vfr_pkg.sv
`timescale 1ns/1ps
package vfr_pkg;

  // Sequencer phases: one element walks FETCH -> ADD -> XOR -> ROT.
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_FETCH = 3'd1,
    S_ADD   = 3'd2,
    S_XOR   = 3'd3,
    S_ROT   = 3'd4
  } seq_state_t;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_XOR = 2'd1,
    OP_ROT = 2'd2
  } alu_op_t;

  // Rotate amounts selected by element number modulo 4.
  localparam int unsigned ROT_LANES = 4;
  localparam int unsigned ROT_TAB [ROT_LANES] = '{16, 12, 8, 7};

endpackage

// File: rtl/vfr_idx_table.sv
`timescale 1ns/1ps
// One packed index table: synchronous write, registered read (RAM style).
module vfr_idx_table #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned AW    = 2,
  parameter int unsigned DW    = 64
)(
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/vfr_regfile.sv
`timescale 1ns/1ps
// State window: one write port, two combinational engine reads, one
// registered host read.
module vfr_regfile #(
  parameter int unsigned NREG = 16,
  parameter int unsigned DW   = 32,
  parameter int unsigned AW   = 4
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ra_addr,
  output logic [DW-1:0] ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [DW-1:0] rb_data,
  input  logic [AW-1:0] rh_addr,
  output logic [DW-1:0] rh_data
);

  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(NREG); i++) regs[i] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rh_data <= '0;
    else     rh_data <= regs[rh_addr];
  end

  assign ra_data = regs[ra_addr];
  assign rb_data = regs[rb_addr];

endmodule

// File: rtl/vfr_alu.sv
`timescale 1ns/1ps
// 32-bit add / xor / rotate-left unit.
module vfr_alu
  import vfr_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned SW = 5
)(
  input  alu_op_t       op,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic [SW-1:0] sh,
  output logic [DW-1:0] res
);

  logic [2*DW-1:0] dbl;

  // Upper half of the doubled word shifted left is the left rotation.
  assign dbl = {opa, opa} << sh;

  always_comb begin
    unique case (op)
      OP_ADD:  res = opa + opb;
      OP_XOR:  res = opa ^ opb;
      default: res = dbl[2*DW-1:DW];
    endcase
  end

endmodule

// File: rtl/vfr_ctrl.sv
`timescale 1ns/1ps
// Element / pass sequencer.
module vfr_ctrl
  import vfr_pkg::*;
#(
  parameter int unsigned VLEN  = 32,
  parameter int unsigned EW    = 5,
  parameter int unsigned REP_W = 8
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [REP_W-1:0] rep_count,
  input  logic             idx_bad,
  output seq_state_t       state_q,
  output logic [EW-1:0]    elem_q,
  output logic             busy,
  output logic             fetch,
  output logic             vec_end,
  output logic             done,
  output logic             err
);

  logic [REP_W-1:0] passes_q;
  logic             last_elem;

  assign last_elem = (elem_q == EW'(VLEN - 1));
  assign busy      = (state_q != S_IDLE);
  assign fetch     = (state_q == S_FETCH);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= S_IDLE;
      elem_q   <= '0;
      passes_q <= '0;
      vec_end  <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      vec_end <= 1'b0;
      done    <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (start) begin
            err    <= 1'b0;
            elem_q <= '0;
            if (rep_count == '0) begin
              done <= 1'b1;
            end else begin
              passes_q <= rep_count;
              state_q  <= S_FETCH;
            end
          end
        end
        S_FETCH: state_q <= S_ADD;
        S_ADD: begin
          if (idx_bad) begin
            err     <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            state_q <= S_XOR;
          end
        end
        S_XOR: state_q <= S_ROT;
        S_ROT: begin
          if (last_elem) begin
            vec_end <= 1'b1;
            elem_q  <= '0;
            if (passes_q == REP_W'(1)) begin
              done    <= 1'b1;
              state_q <= S_IDLE;
            end else begin
              passes_q <= passes_q - REP_W'(1);
              state_q  <= S_FETCH;
            end
          end else begin
            elem_q  <= elem_q + EW'(1);
            state_q <= S_FETCH;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/vfr_seq.sv
`timescale 1ns/1ps
// Top: index tables, state window, ALU and sequencer.
module vfr_seq
  import vfr_pkg::*;
#(
  parameter int unsigned DW       = 32,
  parameter int unsigned NREG     = 16,
  parameter int unsigned VLEN     = 32,
  parameter int unsigned PACK_W   = 64,
  parameter int unsigned IDX_CODE = 3,
  parameter int unsigned REP_W    = 8,
  localparam int unsigned NTAB    = 3,
  localparam int unsigned IDXW    = PACK_W >> IDX_CODE,
  localparam int unsigned LANES   = PACK_W / IDXW,
  localparam int unsigned WPT     = (VLEN + LANES - 1) / LANES,
  localparam int unsigned WAW     = (WPT > 1) ? $clog2(WPT) : 1,
  localparam int unsigned RAW     = $clog2(NREG),
  localparam int unsigned EW      = $clog2(VLEN),
  localparam int unsigned SW      = $clog2(DW)
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              tbl_we,
  input  logic [1:0]        tbl_sel,
  input  logic [WAW-1:0]    tbl_word,
  input  logic [PACK_W-1:0] tbl_wdata,
  input  logic              st_we,
  input  logic [RAW-1:0]    st_waddr,
  input  logic [DW-1:0]     st_wdata,
  input  logic [RAW-1:0]    st_raddr,
  output logic [DW-1:0]     st_rdata,
  input  logic              start,
  input  logic [REP_W-1:0]  rep_count,
  output logic              busy,
  output logic              vec_end,
  output logic              done,
  output logic              err
);

  seq_state_t        state_q;
  logic [EW-1:0]     elem_q;
  logic              fetch;
  logic              idx_bad;
  logic              tbl_acc;
  logic [WAW-1:0]    rd_word;
  int unsigned       lane_off;

  logic [PACK_W-1:0] tab_rd  [NTAB];
  logic [IDXW-1:0]   tab_idx [NTAB];
  logic [RAW-1:0]    a_idx, b_idx, c_idx;

  logic              rf_we;
  logic [RAW-1:0]    rf_waddr, ra_addr, rb_addr;
  logic [DW-1:0]     rf_wdata, ra_data, rb_data, alu_res;
  alu_op_t           alu_op;
  logic [SW-1:0]     rot_sh;

  assign tbl_acc  = tbl_we && !busy;
  assign rd_word  = WAW'(int'(elem_q) / int'(LANES));
  assign lane_off = (int'(elem_q) % int'(LANES)) * int'(IDXW);

  for (genvar t = 0; t < int'(NTAB); t++) begin : g_tab
    vfr_idx_table #(
      .DEPTH (WPT),
      .AW    (WAW),
      .DW    (PACK_W)
    ) u_tab (
      .clk   (clk),
      .we    (tbl_acc && (tbl_sel == 2'(t))),
      .waddr (tbl_word),
      .wdata (tbl_wdata),
      .re    (fetch),
      .raddr (rd_word),
      .rdata (tab_rd[t])
    );
    assign tab_idx[t] = tab_rd[t][lane_off +: IDXW];
  end

  // Window check covers all three operands of the element at once.
  always_comb begin
    idx_bad = 1'b0;
    for (int t = 0; t < int'(NTAB); t++) begin
      if (int'(tab_idx[t]) >= int'(NREG)) idx_bad = 1'b1;
    end
  end

  assign a_idx  = tab_idx[0][RAW-1:0];
  assign b_idx  = tab_idx[1][RAW-1:0];
  assign c_idx  = tab_idx[2][RAW-1:0];
  assign rot_sh = SW'(ROT_TAB[int'(elem_q) % int'(ROT_LANES)]);

  always_comb begin
    rf_we    = 1'b0;
    rf_waddr = st_waddr;
    rf_wdata = st_wdata;
    ra_addr  = a_idx;
    rb_addr  = b_idx;
    alu_op   = OP_ROT;
    unique case (state_q)
      S_IDLE: rf_we = st_we;
      S_ADD: begin
        rf_we    = !idx_bad;
        rf_waddr = a_idx;
        rf_wdata = alu_res;
        alu_op   = OP_ADD;
      end
      S_XOR: begin
        rf_we    = 1'b1;
        rf_waddr = c_idx;
        rf_wdata = alu_res;
        ra_addr  = c_idx;
        rb_addr  = a_idx;
        alu_op   = OP_XOR;
      end
      S_ROT: begin
        rf_we    = 1'b1;
        rf_waddr = c_idx;
        rf_wdata = alu_res;
        ra_addr  = c_idx;
        rb_addr  = a_idx;
      end
      default: ;
    endcase
  end

  vfr_regfile #(
    .NREG (NREG),
    .DW   (DW),
    .AW   (RAW)
  ) u_rf (
    .clk     (clk),
    .rst     (rst),
    .we      (rf_we),
    .waddr   (rf_waddr),
    .wdata   (rf_wdata),
    .ra_addr (ra_addr),
    .ra_data (ra_data),
    .rb_addr (rb_addr),
    .rb_data (rb_data),
    .rh_addr (st_raddr),
    .rh_data (st_rdata)
  );

  vfr_alu #(
    .DW (DW),
    .SW (SW)
  ) u_alu (
    .op  (alu_op),
    .opa (ra_data),
    .opb (rb_data),
    .sh  (rot_sh),
    .res (alu_res)
  );

  vfr_ctrl #(
    .VLEN  (VLEN),
    .EW    (EW),
    .REP_W (REP_W)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .rep_count (rep_count),
    .idx_bad   (idx_bad),
    .state_q   (state_q),
    .elem_q    (elem_q),
    .busy      (busy),
    .fetch     (fetch),
    .vec_end   (vec_end),
    .done      (done),
    .err       (err)
  );

endmodule

// File: rtl/vfr_seq_chk.sv
`timescale 1ns/1ps
module vfr_seq_chk
  import vfr_pkg::*;
#(
  parameter int unsigned VLEN  = 32,
  parameter int unsigned EW    = 5,
  parameter int unsigned REP_W = 8
)(
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [REP_W-1:0] rep_count,
  input logic             busy,
  input logic             done,
  input logic             vec_end,
  input logic             err,
  input seq_state_t       state_q,
  input logic [EW-1:0]    elem_q
);

  // R6: add, xor, rotate of one element follow each other directly
  a_r6_add_then_xor: assert property (@(posedge clk) disable iff (rst)
    state_q == S_ADD |=> (state_q == S_XOR) || (state_q == S_IDLE && err));
  a_r6_xor_then_rot: assert property (@(posedge clk) disable iff (rst)
    state_q == S_XOR |=> state_q == S_ROT);
  a_r6_rot_then_next: assert property (@(posedge clk) disable iff (rst)
    state_q == S_ROT |=> (state_q == S_FETCH) || (state_q == S_IDLE));
  a_r6_busy_from_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  // R7: pass end only after the rotate of the last element
  a_r7_vec_end_last: assert property (@(posedge clk) disable iff (rst)
    vec_end |-> ($past(state_q) == S_ROT) && ($past(elem_q) == EW'(VLEN - 1)));
  a_r7_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && !err);

  // R9: error arises only from the add phase and is held until a new start
  a_r9_err_from_add: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> ($past(state_q) == S_ADD) && !busy);
  a_r9_err_hold: assert property (@(posedge clk) disable iff (rst)
    (err && !(start && !busy)) |=> err);

  // R10: zero repeat count finishes at once
  a_r10_zero_rep: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && rep_count == '0) |=> done && !busy);

endmodule

bind vfr_seq vfr_seq_chk #(
  .VLEN  (VLEN),
  .EW    (EW),
  .REP_W (REP_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .rep_count (rep_count),
  .busy      (busy),
  .done      (done),
  .vec_end   (vec_end),
  .err       (err),
  .state_q   (state_q),
  .elem_q    (elem_q)
);

// File: tb/sim_vfr_seq.sv
`timescale 1ns/1ps
module sim_vfr_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tbl_we = 1'b0;
  logic [1:0]  tbl_sel = '0;
  logic [1:0]  tbl_word = '0;
  logic [63:0] tbl_wdata = '0;
  logic        st_we = 1'b0;
  logic [3:0]  st_waddr = '0;
  logic [31:0] st_wdata = '0;
  logic [3:0]  st_raddr = '0;
  logic [31:0] st_rdata;
  logic        start = 1'b0;
  logic [7:0]  rep_count = '0;
  logic        busy, vec_end, done, err;

  vfr_seq u0 (
    .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_sel(tbl_sel),
    .tbl_word(tbl_word), .tbl_wdata(tbl_wdata), .st_we(st_we),
    .st_waddr(st_waddr), .st_wdata(st_wdata), .st_raddr(st_raddr),
    .st_rdata(st_rdata), .start(start), .rep_count(rep_count),
    .busy(busy), .vec_end(vec_end), .done(done), .err(err)
  );

  always #2.5 clk = ~clk;

  int nchk = 0;
  int nfail = 0;
  logic [31:0] mdl [16];

  // Quarter-round operand sets: four columns then four diagonals.
  localparam int QA [8] = '{0, 1, 2, 3, 0, 1, 2, 3};
  localparam int QB [8] = '{4, 5, 6, 7, 5, 6, 7, 4};
  localparam int QC [8] = '{8, 9, 10, 11, 10, 11, 8, 9};
  localparam int QD [8] = '{12, 13, 14, 15, 15, 12, 13, 14};

  // Stimulus vectors: {state seed, repeat count}
  localparam int NCASE = 4;
  localparam logic [39:0] CASES [NCASE] = '{
    {32'h0000_0000, 8'd1},
    {32'h0123_4567, 8'd2},
    {32'hFFFF_FFFF, 8'd10},
    {32'hA5A5_5A5A, 8'd3}
  };

  function automatic int tbl_index(input int t, input int e);
    int q = e / 4;
    bit ev = ((e % 4) % 2) == 0;
    case (t)
      0:       return ev ? QA[q] : QC[q];
      1:       return ev ? QB[q] : QD[q];
      default: return ev ? QD[q] : QB[q];
    endcase
  endfunction

  function automatic logic [63:0] pack_word(input int t, input int w);
    logic [63:0] r = '0;
    for (int k = 0; k < 8; k++) r[8*k +: 8] = 8'(tbl_index(t, 8*w + k));
    return r;
  endfunction

  function automatic logic [31:0] rl(input logic [31:0] v, input int s);
    return (v << s) | (v >> (32 - s));
  endfunction

  task automatic qr(input int a, input int b, input int c, input int d);
    mdl[a] = mdl[a] + mdl[b]; mdl[d] = rl(mdl[d] ^ mdl[a], 16);
    mdl[c] = mdl[c] + mdl[d]; mdl[b] = rl(mdl[b] ^ mdl[c], 12);
    mdl[a] = mdl[a] + mdl[b]; mdl[d] = rl(mdl[d] ^ mdl[a], 8);
    mdl[c] = mdl[c] + mdl[d]; mdl[b] = rl(mdl[b] ^ mdl[c], 7);
  endtask

  task automatic model_pass();
    for (int q = 0; q < 8; q++) qr(QA[q], QB[q], QC[q], QD[q]);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic load_word(input int t, input int w, input logic [63:0] d);
    @(negedge clk);
    tbl_we = 1'b1; tbl_sel = 2'(t); tbl_word = 2'(w); tbl_wdata = d;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic load_tables();
    for (int t = 0; t < 3; t++)
      for (int w = 0; w < 4; w++) load_word(t, w, pack_word(t, w));
  endtask

  task automatic write_state(input logic [31:0] seed);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      st_we = 1'b1; st_waddr = 4'(i);
      st_wdata = seed + 32'(i) * 32'h9E37_79B9;
      mdl[i] = st_wdata;
    end
    @(negedge clk);
    st_we = 1'b0;
  endtask

  task automatic check_state(input string tag);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); st_raddr = 4'(i);
      @(negedge clk); check(tag, st_rdata, mdl[i]);
    end
  endtask

  // Start a run and count busy cycles, pass pulses and done pulses.
  task automatic run(input int rep, input bit poke,
                     output int cyc, output int ve, output int dn);
    int guard = 0;
    cyc = 0; ve = 0; dn = 0;
    @(negedge clk);
    start = 1'b1; rep_count = 8'(rep);
    forever begin
      @(negedge clk);
      start = 1'b0;
      tbl_we = 1'b0; st_we = 1'b0;
      if (busy) cyc++;
      if (vec_end) ve++;
      if (done) dn++;
      if (!busy) break;
      if (poke && guard == 10) begin
        tbl_we = 1'b1; tbl_sel = 2'd0; tbl_word = 2'd0; tbl_wdata = '1;
        st_we = 1'b1; st_waddr = 4'd0; st_wdata = 32'hDEAD_BEEF;
      end
      guard++;
      if (guard > 5000) begin
        nchk++; nfail++;
        $display("FAIL R6: run did not finish, actual %0d cycles expected %0d", guard, 128*rep);
        break;
      end
    end
  endtask

  bit finished = 1'b0;

  initial begin
    #(150000 * 5);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int cyc, ve, dn;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state and R1 registered readback of cleared words
    check("R1 busy", 32'(busy), 0);
    check("R1 done", 32'(done), 0);
    check("R1 vec_end", 32'(vec_end), 0);
    check("R1 err", 32'(err), 0);
    st_raddr = 4'd0; @(negedge clk); check("R1 word0", st_rdata, 0);
    st_raddr = 4'd15; @(negedge clk); check("R1 word15", st_rdata, 0);

    load_tables();

    // Vector table: R2/R3/R4/R5 data path, R6 timing, R7 pass pulses
    for (int n = 0; n < NCASE; n++) begin
      int rep = int'(CASES[n][7:0]);
      write_state(CASES[n][39:8]);
      run(rep, 1'b0, cyc, ve, dn);
      for (int p = 0; p < rep; p++) model_pass();
      check("R6 busy cycles", 32'(cyc), 32'(128 * rep));
      check("R7 vec_end count", 32'(ve), 32'(rep));
      check("R7 done count", 32'(dn), 1);
      check_state("R2/R3/R4/R5 state");
    end

    // R8: table and state writes during a run are ignored
    write_state(32'h1357_9BDF);
    run(1, 1'b1, cyc, ve, dn);
    model_pass();
    check("R8 poke run cycles", 32'(cyc), 128);
    check_state("R8 poked run");
    run(1, 1'b0, cyc, ve, dn);
    model_pass();
    check_state("R8 tables kept");

    // R9: out-of-window index at element 0 halts before any write
    write_state(32'h2468_ACE0);
    load_word(1, 0, {pack_word(1, 0)[63:8], 8'h10});
    run(1, 1'b0, cyc, ve, dn);
    check("R9 err", 32'(err), 1);
    check("R9 busy cycles", 32'(cyc), 2);
    check("R9 no done", 32'(dn), 0);
    check("R9 no vec_end", 32'(ve), 0);
    check_state("R9 state untouched");
    check("R9 err held", 32'(err), 1);
    load_word(1, 0, pack_word(1, 0));

    // R10: zero repeat count; also clears err (R9)
    run(0, 1'b0, cyc, ve, dn);
    check("R10 done", 32'(dn), 1);
    check("R10 busy", 32'(cyc), 0);
    check("R9 err cleared", 32'(err), 0);
    check_state("R10 state untouched");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule